// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps one processor's private cache coherent with its peers on a single shared bus. It holds a small direct-mapped array of tags and line states. It serves processor reads and writes and raises bus requests for fills, ownership upgrades and dirty writebacks. It also watches the transactions other caches put on the bus. The protocol is write-invalidate and write-back. Each line is in one of four states: invalid, shared (read only, other copies may exist), clean-private (read only, the only copy, memory up to date) and dirty (read/write, the only copy, memory stale).

Keeping clean-private apart from dirty lets a processor that read a line nobody else holds write it later without any bus traffic. A snoop can then tell whether memory needs the data. The processor holds its request until a one-cycle done pulse. The bus side uses a plain request/grant handshake. Snoop responses (shared, flush) appear one cycle after the snooped transaction. The data path is not modelled: a flush pulse stands for the dirty data being supplied, and the address is the one that was snooped.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After reset every line is invalid and `bus_req`, `cpu_done`, `snp_shared` and `snp_flush` are low. The first access to any address therefore misses.
- R2: A processor read miss raises `bus_req` with `bus_cmd`=00 (read) and `bus_addr` equal to the request address. In the grant cycle the line is filled as clean-private if `bus_shared_in` is low and as shared if it is high. `cpu_done` pulses the cycle after the grant.
- R3: The following complete with `cpu_done` one cycle after the request and no bus request: a read that hits a valid line, a write that hits a dirty line, and a write that hits a clean-private line. The last case also turns the line dirty without any bus transaction.
- R4: A processor write that misses or hits a shared line raises `bus_cmd`=01 (read-exclusive). At grant the line becomes dirty. This holds even if a snoop invalidated the line while the request waited.
- R5: A miss whose index holds a dirty line of another tag first requests `bus_cmd`=10 (writeback) with the victim's address (`{victim tag, index}`). The victim is then invalid and the fill request for the new line follows.
- R6: A snooped read (`snp_cmd`=00) that hits a valid line asserts `snp_shared` the next cycle and leaves the line shared. If the line was dirty, `snp_flush` is also asserted. A snoop that misses gives no response.
- R7: A snooped read-exclusive (01) or invalidate (11) that hits a valid line makes it invalid and does not assert `snp_shared`. A dirty line asserts `snp_flush`.
- R8: A snooped writeback (10) has no effect on any line and gives no response.
- R9: Once raised, `bus_req`, `bus_cmd` and `bus_addr` stay unchanged until the cycle in which `bus_gnt` is high.
- R10: When a snoop and the start of a processor request fall in the same cycle, the snoop is applied first. The processor request is evaluated in a later snoop-free cycle against the updated line state.
- Address split: index = `cpu_addr[IDX_W-1:0]`, tag = upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_cmd | output | 2 | 00 read, 01 read-exclusive, 10 writeback |
| bus_addr | output | ADDR_W | Address of the bus request |
| bus_gnt | input | 1 | Grant; the request is performed in this cycle |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at grant) |
| snp_valid | input | 1 | A foreign bus transaction is present |
| snp_cmd | input | 2 | 00 read, 01 read-exclusive, 10 writeback, 11 invalidate |
| snp_addr | input | ADDR_W | Address of the snooped transaction |
| snp_shared | output | 1 | This cache keeps a copy (one cycle after the snoop) |
| snp_flush | output | 1 | This cache supplies dirty data (one cycle after the snoop) |

## Verification
The assertions take several properties of the environment as given. `bus_gnt` only arrives while `bus_req` is high. A foreign transaction is never snooped in the same cycle that this cache owns the bus. The processor keeps a single request outstanding and holds it until done. The bench grants only after seeing `bus_req` at the falling edge and clears every grant after one cycle. It injects snoops either alone, together with the start of a processor request, or in the first waiting cycle of a bus request whose grant is delayed at least one cycle, so a snoop and a grant never meet.

// File: rtl/coh_pkg.sv
package coh_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_CLP = 2'b10,
      LN_DRT = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      OP_RD  = 2'b00,
      OP_RDX = 2'b01,
      OP_WB  = 2'b10,
      OP_INV = 2'b11
   } bus_op_t;

   // state a line moves to when a foreign transaction hits it
   function automatic line_st_t snoop_next(line_st_t cur, bus_op_t op);
      line_st_t r;
      r = cur;
      if (cur != LN_INV) begin
         case (op)
            OP_RD:          r = LN_SHR;
            OP_RDX, OP_INV: r = LN_INV;
            default:        r = cur;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/coh_tag_array.sv
module coh_tag_array
   import coh_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output line_st_t         a_st,
   output logic [TAG_W-1:0] a_tag,
   input  logic [IDX_W-1:0] b_idx,
   output line_st_t         b_st,
   output logic [TAG_W-1:0] b_tag,
   input  logic             s_we,
   input  logic [IDX_W-1:0] s_idx,
   input  line_st_t         s_st,
   input  logic             f_we,
   input  logic [IDX_W-1:0] f_idx,
   input  logic [TAG_W-1:0] f_tag,
   input  line_st_t         f_st
);
   localparam int LINES = 1 << IDX_W;

   logic [2*LINES-1:0]     st_flat;
   logic [TAG_W*LINES-1:0] tag_flat;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_t         st_q;
      logic [TAG_W-1:0] tag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            st_q  <= LN_INV;
            tag_q <= '0;
         end else if (s_we && s_idx == IDX_W'(i)) begin
            st_q <= s_st;
         end else if (f_we && f_idx == IDX_W'(i)) begin
            st_q  <= f_st;
            tag_q <= f_tag;
         end
      end
      assign st_flat[2*i +: 2]          = st_q;
      assign tag_flat[TAG_W*i +: TAG_W] = tag_q;
   end

   assign a_st  = line_st_t'(st_flat[2*int'(a_idx) +: 2]);
   assign a_tag = tag_flat[TAG_W*int'(a_idx) +: TAG_W];
   assign b_st  = line_st_t'(st_flat[2*int'(b_idx) +: 2]);
   assign b_tag = tag_flat[TAG_W*int'(b_idx) +: TAG_W];

   // snoop and request side never update the same line in one cycle (R10)
   p_no_write_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(s_we && f_we && s_idx == f_idx));

endmodule

// File: rtl/coh_req_fsm.sv
module coh_req_fsm
   import coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_wr,
   input  logic [ADDR_W-1:0]       cpu_addr,
   output logic                    cpu_done,
   input  logic                    snp_busy,
   input  line_st_t                rd_st,
   input  logic [ADDR_W-IDX_W-1:0] rd_tag,
   output logic                    bus_req,
   output logic [1:0]              bus_cmd,
   output logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_gnt,
   input  logic                    bus_shared_in,
   output logic                    f_we,
   output logic [IDX_W-1:0]        f_idx,
   output logic [ADDR_W-IDX_W-1:0] f_tag,
   output line_st_t                f_st
);
   localparam int TAG_W = ADDR_W - IDX_W;

   typedef enum logic [1:0] {F_IDLE, F_WB, F_FILL, F_DONE} fsm_t;

   fsm_t              fsm_q, fsm_d;
   logic [ADDR_W-1:0] addr_q, vaddr_q;
   bus_op_t           fcmd_q;
   logic              ld;
   logic              hit;
   logic [IDX_W-1:0]  cpu_idx;
   logic [TAG_W-1:0]  cpu_tag;

   assign cpu_idx = cpu_addr[IDX_W-1:0];
   assign cpu_tag = cpu_addr[ADDR_W-1:IDX_W];
   assign hit     = (rd_st != LN_INV) && (rd_tag == cpu_tag);

   always_comb begin
      fsm_d = fsm_q;
      ld    = 1'b0;
      f_we  = 1'b0;
      f_idx = addr_q[IDX_W-1:0];
      f_tag = addr_q[ADDR_W-1:IDX_W];
      f_st  = LN_INV;
      case (fsm_q)
         F_IDLE: if (cpu_req && !snp_busy) begin
            if (hit && (!cpu_wr || rd_st == LN_DRT)) begin
               fsm_d = F_DONE;
            end else if (hit && rd_st == LN_CLP) begin
               f_we  = 1'b1;
               f_idx = cpu_idx;
               f_tag = cpu_tag;
               f_st  = LN_DRT;
               fsm_d = F_DONE;
            end else begin
               ld    = 1'b1;
               fsm_d = (!hit && rd_st == LN_DRT) ? F_WB : F_FILL;
            end
         end
         F_WB: if (bus_gnt) begin
            f_we  = 1'b1;
            f_idx = vaddr_q[IDX_W-1:0];
            f_tag = vaddr_q[ADDR_W-1:IDX_W];
            f_st  = LN_INV;
            fsm_d = F_FILL;
         end
         F_FILL: if (bus_gnt) begin
            f_we  = 1'b1;
            f_st  = (fcmd_q == OP_RDX) ? LN_DRT : (bus_shared_in ? LN_SHR : LN_CLP);
            fsm_d = F_DONE;
         end
         default: fsm_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsm_q   <= F_IDLE;
         addr_q  <= '0;
         vaddr_q <= '0;
         fcmd_q  <= OP_RD;
      end else begin
         fsm_q <= fsm_d;
         if (ld) begin
            addr_q  <= cpu_addr;
            vaddr_q <= {rd_tag, cpu_idx};
            fcmd_q  <= cpu_wr ? OP_RDX : OP_RD;
         end
      end
   end

   assign bus_req  = (fsm_q == F_WB) || (fsm_q == F_FILL);
   assign bus_cmd  = (fsm_q == F_WB) ? OP_WB : fcmd_q;
   assign bus_addr = (fsm_q == F_WB) ? vaddr_q : addr_q;
   assign cpu_done = (fsm_q == F_DONE);

   p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_gnt |-> bus_req);
   p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
   p_fill_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_gnt && bus_cmd == OP_WB) |=>
         (bus_req && bus_cmd != OP_WB &&
          bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0])));
   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
   import coh_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_wr,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   output logic              bus_req,
   output logic [1:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || TAG_W < 1) begin : g_bad_cfg
      $error("snoop_coh_ctrl: IDX_W must be in 1..ADDR_W-1");
   end

   line_st_t         a_st, b_st, s_st, f_st;
   logic [TAG_W-1:0] a_tag, b_tag, f_tag;
   logic [IDX_W-1:0] f_idx;
   logic             f_we, s_we, s_hit;
   bus_op_t          s_op;
   logic             shared_q, flush_q;

   assign s_op  = bus_op_t'(snp_cmd);
   assign s_hit = (b_st != LN_INV) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);
   assign s_we  = snp_valid && s_hit && (s_op != OP_WB);
   assign s_st  = snoop_next(b_st, s_op);

   coh_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
      .clk   (clk),
      .rst_n (rst_n),
      .a_idx (cpu_addr[IDX_W-1:0]),
      .a_st  (a_st),
      .a_tag (a_tag),
      .b_idx (snp_addr[IDX_W-1:0]),
      .b_st  (b_st),
      .b_tag (b_tag),
      .s_we  (s_we),
      .s_idx (snp_addr[IDX_W-1:0]),
      .s_st  (s_st),
      .f_we  (f_we),
      .f_idx (f_idx),
      .f_tag (f_tag),
      .f_st  (f_st)
   );

   coh_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req       (cpu_req),
      .cpu_wr        (cpu_wr),
      .cpu_addr      (cpu_addr),
      .cpu_done      (cpu_done),
      .snp_busy      (snp_valid),
      .rd_st         (a_st),
      .rd_tag        (a_tag),
      .bus_req       (bus_req),
      .bus_cmd       (bus_cmd),
      .bus_addr      (bus_addr),
      .bus_gnt       (bus_gnt),
      .bus_shared_in (bus_shared_in),
      .f_we          (f_we),
      .f_idx         (f_idx),
      .f_tag         (f_tag),
      .f_st          (f_st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shared_q <= 1'b0;
         flush_q  <= 1'b0;
      end else begin
         shared_q <= snp_valid && s_hit && (s_op == OP_RD);
         flush_q  <= snp_valid && s_hit && (b_st == LN_DRT) && (s_op != OP_WB);
      end
   end

   assign snp_shared = shared_q;
   assign snp_flush  = flush_q;

   p_no_snoop_at_gnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(snp_valid && bus_gnt));
   p_flush_follows_snoop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> $past(snp_valid && snp_cmd != OP_WB));
   p_shared_only_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared |-> $past(snp_valid && snp_cmd == OP_RD));

endmodule

// File: tb/snoop_coh_ctrl_test.sv
module snoop_coh_ctrl_test;
   localparam int AW = 12;
   localparam int IW = 4;
   localparam int LN = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_wr = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_done;
   logic          bus_req;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic          bus_gnt = 1'b0, bus_shared_in = 1'b0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = '0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_shared, snp_flush;

   always #5 clk = ~clk;

   snoop_coh_ctrl #(.ADDR_W(AW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_done(cpu_done), .bus_req(bus_req),
      .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
      .bus_shared_in(bus_shared_in), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
      .snp_addr(snp_addr), .snp_shared(snp_shared), .snp_flush(snp_flush));

   int    checks = 0;
   int    fails = 0;
   string cur_req = "R1";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   // behavioural reference: 0 invalid, 1 shared, 2 clean-private, 3 dirty
   int m_st[LN];
   int m_tag[LN];
   int ph, fcmd, laddr, vaddr, e_sh, e_fl;

   always @(posedge clk) begin
      int ix, tg, nsh, nfl;
      bit hit;
      if (!rst_n) begin
         for (int k = 0; k < LN; k++) begin m_st[k] = 0; m_tag[k] = 0; end
         ph = 0; fcmd = 0; laddr = 0; vaddr = 0; e_sh = 0; e_fl = 0;
      end else begin
         nsh = 0; nfl = 0;
         if (snp_valid) begin
            ix = int'(snp_addr) % LN; tg = int'(snp_addr) / LN;
            if (m_st[ix] != 0 && m_tag[ix] == tg) begin
               if (snp_cmd == 2'b00) begin
                  nsh = 1; nfl = (m_st[ix] == 3); m_st[ix] = 1;
               end else if (snp_cmd != 2'b10) begin
                  nfl = (m_st[ix] == 3); m_st[ix] = 0;
               end
            end
         end
         case (ph)
            0: if (cpu_req && !snp_valid) begin
               ix = int'(cpu_addr) % LN; tg = int'(cpu_addr) / LN;
               hit = (m_st[ix] != 0) && (m_tag[ix] == tg);
               if (hit && (!cpu_wr || m_st[ix] == 3)) ph = 3;
               else if (hit && m_st[ix] == 2) begin m_st[ix] = 3; ph = 3; end
               else begin
                  fcmd = cpu_wr ? 1 : 0; laddr = int'(cpu_addr);
                  if (!hit && m_st[ix] == 3) begin vaddr = m_tag[ix] * LN + ix; ph = 1; end
                  else ph = 2;
               end
            end
            1: if (bus_gnt) begin m_st[vaddr % LN] = 0; ph = 2; end
            2: if (bus_gnt) begin
               ix = laddr % LN; m_tag[ix] = laddr / LN;
               m_st[ix] = (fcmd == 1) ? 3 : (bus_shared_in ? 1 : 2);
               ph = 3;
            end
            default: ph = 0;
         endcase
         e_sh = nsh; e_fl = nfl;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "bus_req", int'(bus_req), (ph == 1 || ph == 2) ? 1 : 0);
         if (ph == 1 || ph == 2) begin
            chk(cur_req, "bus_cmd", int'(bus_cmd), (ph == 1) ? 2 : fcmd);
            chk(cur_req, "bus_addr", int'(bus_addr), (ph == 1) ? vaddr : laddr);
         end
         chk(cur_req, "cpu_done", int'(cpu_done), (ph == 3) ? 1 : 0);
         chk(cur_req, "snp_shared", int'(snp_shared), e_sh);
         chk(cur_req, "snp_flush", int'(snp_flush), e_fl);
      end
   end

   task automatic cpu_op(input bit wr, input int addr, input int dly, input bit shr,
                         input bit inj, input int icmd, input int iaddr, input bit snp_first,
                         output int lat, output int grants);
      int w;
      bit injected;
      lat = 0; grants = 0; w = 0; injected = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_wr = wr; cpu_addr = AW'(addr);
      if (snp_first) begin
         snp_valid = 1'b1; snp_cmd = 2'(icmd); snp_addr = AW'(iaddr); injected = 1;
      end
      forever begin
         @(negedge clk);
         lat++;
         snp_valid = 1'b0; bus_gnt = 1'b0; bus_shared_in = 1'b0;
         if (cpu_done) break;
         if (bus_req) begin
            if (inj && !injected && w == 0 && dly > 0) begin
               snp_valid = 1'b1; snp_cmd = 2'(icmd); snp_addr = AW'(iaddr); injected = 1;
            end
            if (w == dly) begin
               bus_gnt = 1'b1; bus_shared_in = shr; grants++; w = 0;
            end else w++;
         end
      end
      cpu_req = 1'b0;
   endtask

   task automatic snoop(input int cmd, input int addr, input int esh, input int efl,
                        input string tag);
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(addr);
      @(negedge clk);
      snp_valid = 1'b0;
      chk(tag, "snoop shared", int'(snp_shared), esh);
      chk(tag, "snoop flush", int'(snp_flush), efl);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int lat, g;
      int pool[6];
      pool = '{12'h005, 12'h015, 12'h025, 12'h033, 12'h133, 12'h044};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R1";
      chk("R1", "reset bus_req", int'(bus_req), 0);
      chk("R1", "reset cpu_done", int'(cpu_done), 0);
      chk("R1", "reset snp_shared", int'(snp_shared), 0);
      chk("R1", "reset snp_flush", int'(snp_flush), 0);
      cpu_op(0, 12'h0F0, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R1", "first read misses", g, 1);

      cur_req = "R2";
      cpu_op(0, 12'h005, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R2", "read miss grants", g, 1);
      chk("R2", "read miss latency", lat, 2);

      cur_req = "R3";
      cpu_op(0, 12'h005, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R3", "read hit latency", lat, 1);
      chk("R3", "read hit grants", g, 0);
      cpu_op(1, 12'h005, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R3", "silent upgrade grants", g, 0);
      chk("R3", "silent upgrade latency", lat, 1);

      cur_req = "R6";
      snoop(0, 12'h005, 1, 1, "R6");
      snoop(0, 12'h005, 1, 0, "R6");

      cur_req = "R4";
      cpu_op(1, 12'h005, 1, 0, 0, 0, 0, 0, lat, g);
      chk("R4", "shared write grants", g, 1);

      cur_req = "R5";
      cpu_op(0, 12'h015, 0, 1, 0, 0, 0, 0, lat, g);
      chk("R5", "dirty victim grants", g, 2);
      snoop(0, 12'h005, 0, 0, "R5");
      snoop(0, 12'h015, 1, 0, "R5");

      cur_req = "R7";
      snoop(3, 12'h015, 0, 0, "R7");
      cpu_op(0, 12'h015, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R7", "refetch after invalidate", g, 1);

      cur_req = "R6";
      snoop(0, 12'h015, 1, 0, "R6");
      cpu_op(1, 12'h015, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R6", "write after shared demote", g, 1);

      cur_req = "R5";
      cpu_op(1, 12'h025, 2, 0, 0, 0, 0, 0, lat, g);
      chk("R5", "write miss dirty victim grants", g, 2);
      snoop(0, 12'h015, 0, 0, "R5");

      cur_req = "R7";
      cpu_op(1, 12'h120, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R4", "write miss grants", g, 1);
      snoop(1, 12'h120, 0, 1, "R7");
      snoop(0, 12'h120, 0, 0, "R7");

      cur_req = "R8";
      cpu_op(1, 12'h033, 0, 0, 0, 0, 0, 0, lat, g);
      snoop(2, 12'h033, 0, 0, "R8");
      snoop(0, 12'h033, 1, 1, "R8");

      cur_req = "R10";
      cpu_op(1, 12'h033, 0, 0, 0, 0, 0, 0, lat, g);
      chk("R10", "reacquire grants", g, 1);
      cpu_op(1, 12'h033, 0, 0, 0, 0, 12'h033, 1, lat, g);
      chk("R10", "snoop first then write grants", g, 1);
      chk("R10", "deferred write latency", lat, 3);

      cur_req = "R9";
      cpu_op(0, 12'h044, 4, 1, 0, 0, 0, 0, lat, g);
      chk("R9", "delayed grant count", g, 1);
      chk("R9", "delayed grant latency", lat, 6);
      cur_req = "R4";
      cpu_op(1, 12'h044, 3, 0, 1, 3, 12'h044, 0, lat, g);
      chk("R4", "upgrade raced by invalidate", g, 1);
      snoop(0, 12'h044, 1, 1, "R4");

      cur_req = "R9";
      for (int n = 0; n < 80; n++) begin
         int r, a, b;
         r = int'($urandom % 4);
         a = pool[$urandom % 6];
         b = pool[$urandom % 6];
         if (r == 0) begin
            @(negedge clk);
            snp_valid = 1'b1; snp_cmd = 2'($urandom % 4); snp_addr = AW'(a);
            @(negedge clk);
            snp_valid = 1'b0;
         end else begin
            cpu_op(bit'($urandom % 2), a, 1 + int'($urandom % 3), bit'($urandom % 2),
                   1, int'($urandom % 4), b, bit'(r == 3), lat, g);
         end
      end

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule